// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block watches three supply-good flags and one power-fail flag, all coming from analog comparators. It produces a system reset for the rest of the chip. The reset is raised whenever any supply reads low, while a manual reset request is held, or when a watchdog expires.

The reset comes back off only after a hold-off time. The hold-off starts once every cause has cleared. A 2-bit code picks it from four lengths that double from one code to the next. The same code sets the width of the single reset pulse that follows each watchdog expiry.

All timing is counted in an external millisecond tick, so long periods come from a cheap strobe instead of a wide divider. The power-fail output is a synchronized copy of its own comparator flag. It shares nothing with the reset path.

Top module: `supply_supervisor`

## Requirements
- R1: When any bit of `supply_ok_i` goes low, the reset output is asserted after the third rising clock edge following the change and not after the second.
- R2: Once all supplies are good and no other cause is present, the reset stays asserted for exactly P ticks and is then released. With the tick high every cycle, it is seen asserted for P+1 cycles after the last supply input goes good. A supply dropping during the hold-off restarts the full count.
- R3: P = BASE_TICKS × 2^`tsel_i`. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 times BASE_TICKS, which is 50, 100, 200 and 400 ms at the default BASE_TICKS of 50. Code 2 (200 ms) is the nominal setting.
- R4: The watchdog counts ticks since the last transition, rising or falling, on the synchronized `wd_strobe_i`. It expires after WD_TICKS ticks with no transition. With the tick high every cycle, it fires WD_TICKS+3 cycles after the last strobe change.
- R5: Each expiry produces one reset pulse lasting exactly P ticks. The watchdog count is held clear while the reset is asserted and restarts on release. With the tick high every cycle, the output is therefore deasserted for WD_TICKS+1 cycles between pulses and asserted for P cycles.
- R6: While the synchronized `wd_enable_i` is low, the watchdog never causes a reset. After enable rises, expiry follows WD_TICKS+2 cycles later (with the tick high every cycle).
- R7: Manual reset (`man_rst_i` high) asserts the reset with the same latency as R1. It holds the reset for P ticks after release, as in R2, and keeps the watchdog cleared.
- R8: Parameter RST_ACT_LOW = 1 makes `sys_rst_o` low when active. RST_ACT_LOW = 0 makes it high when active.
- R9: `pwr_fail_no` equals `pwr_ok_i` delayed by two rising clock edges, so it is low while the monitored level is below its trip point. It is unaffected by the reset, manual reset and watchdog state.
- R10: The hold-off and watchdog counts advance only on clock edges where `tick_i` is high. With the tick held low, an asserted reset is never released.
- R11: While `rst_ni` is low, the reset output is asserted and `pwr_fail_no` is low. After `rst_ni` rises with all supplies good, the reset is released as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| tick_i | input | 1 | Synchronous one-cycle millisecond tick |
| supply_ok_i | input | N_SUP | Supply-good comparator flags, asynchronous, 1 = good |
| pwr_ok_i | input | 1 | Power-fail comparator flag, asynchronous, 1 = above trip |
| wd_strobe_i | input | 1 | Watchdog kick, either edge, asynchronous |
| wd_enable_i | input | 1 | Watchdog enable, asynchronous |
| man_rst_i | input | 1 | Manual reset request, active high, asynchronous |
| tsel_i | input | 2 | Hold-off / pulse length select |
| sys_rst_o | output | 1 | System reset, polarity set by RST_ACT_LOW |
| pwr_fail_no | output | 1 | Power-fail flag, active low |

## Verification
The bench builds the block with BASE_TICKS = 4 and WD_TICKS = 40, and holds the tick high for most of the run. With these values, all four select codes, hold-off restarts and several back-to-back watchdog cycles can be measured to the exact cycle within a few thousand clocks. A second instance with RST_ACT_LOW = 0 runs from the same stimulus and is compared against the first at every check. One scenario holds the tick low to show that timing stops with it.

// File: rtl/supsv_pkg.sv
package supsv_pkg;
  // hold-off / pulse length in ticks for a select code
  function automatic int unsigned hold_ticks(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/supsv_hold.sv
module supsv_hold #(
  parameter int unsigned BASE_TICKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic [1:0] tsel_i,
  output logic       active_o
);
  localparam int unsigned MAX_T = supsv_pkg::hold_ticks(BASE_TICKS, 2'd3);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt, last;

  assign last = CNT_W'(supsv_pkg::hold_ticks(BASE_TICKS, tsel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (req_i) begin
      active_o <= 1'b1;
      cnt      <= '0;
    end else if (active_o && tick_i) begin
      // >= so a shortened select mid-count still releases
      if (cnt >= last) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_REQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> active_o); // R1
  AST_RELEASE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> !$past(req_i)); // R2
  AST_NO_TICK_NO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i) |=> active_o); // R10
endmodule

// File: rtl/supsv_wdog.sv
module supsv_wdog #(
  parameter int unsigned WD_TICKS = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic strobe_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(WD_TICKS + 1);

  logic [WD_W-1:0] cnt;
  logic            strobe_q;
  logic            kick;

  assign kick = strobe_i ^ strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      strobe_q <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      expire_o <= 1'b0;
      if (!en_i || clr_i || kick) begin
        cnt <= '0;
      end else if (tick_i) begin
        if (cnt == WD_W'(WD_TICKS - 1)) begin
          cnt      <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt <= cnt + WD_W'(1);
        end
      end
    end
  end

  AST_WD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R5
  AST_WD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !expire_o); // R6
  AST_WD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expire_o); // R7
  AST_WD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expire_o) |-> $past(tick_i)); // R10
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int          N_SUP       = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned BASE_TICKS  = 50,
  parameter int unsigned WD_TICKS    = 1200,
  parameter bit          RST_ACT_LOW = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_SUP-1:0] supply_ok_i,
  input  logic             pwr_ok_i,
  input  logic             wd_strobe_i,
  input  logic             wd_enable_i,
  input  logic             man_rst_i,
  input  logic [1:0]       tsel_i,
  output logic             sys_rst_o,
  output logic             pwr_fail_no
);
  localparam int RAW_W = N_SUP + 4;

  logic [RAW_W-1:0] raw, syn;
  logic [N_SUP-1:0] sup_s;
  logic             pok_s, strobe_s, en_s, man_s;
  logic             wd_expire, active, hold_req;

  assign raw = {man_rst_i, wd_enable_i, wd_strobe_i, pwr_ok_i, supply_ok_i};

  supsv_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  assign sup_s    = syn[N_SUP-1:0];
  assign pok_s    = syn[N_SUP];
  assign strobe_s = syn[N_SUP+1];
  assign en_s     = syn[N_SUP+2];
  assign man_s    = syn[N_SUP+3];

  assign hold_req = ~&sup_s | man_s | wd_expire;

  supsv_hold #(.BASE_TICKS(BASE_TICKS)) u_hold (
    .clk_i, .rst_ni, .tick_i,
    .req_i(hold_req), .tsel_i, .active_o(active)
  );

  supsv_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
    .clk_i, .rst_ni, .tick_i,
    .en_i(en_s), .strobe_i(strobe_s), .clr_i(active | man_s),
    .expire_o(wd_expire)
  );

  generate
    if (RST_ACT_LOW) begin : g_act_low
      assign sys_rst_o = ~active;
    end else begin : g_act_high
      assign sys_rst_o = active;
    end
  endgenerate

  assign pwr_fail_no = pok_s;

  AST_RELEASE_ALL_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> $past(&sup_s)); // R2
  AST_MAN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_s |=> active); // R7
endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam int WD   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] sup = 3'b111;
  logic       pok = 1'b1;
  logic       strobe = 1'b0;
  logic       wd_en = 1'b0;
  logic       man = 1'b0;
  logic [1:0] tsel = 2'd2;
  logic       rst_l, rst_h, pf_n, pf_n2;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_supervisor #(.BASE_TICKS(BASE), .WD_TICKS(WD), .RST_ACT_LOW(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup), .pwr_ok_i(pok),
    .wd_strobe_i(strobe), .wd_enable_i(wd_en), .man_rst_i(man), .tsel_i(tsel),
    .sys_rst_o(rst_l), .pwr_fail_no(pf_n)
  );

  supply_supervisor #(.BASE_TICKS(BASE), .WD_TICKS(WD), .RST_ACT_LOW(1'b0)) uut_ah (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup), .pwr_ok_i(pok),
    .wd_strobe_i(strobe), .wd_enable_i(wd_en), .man_rst_i(man), .tsel_i(tsel),
    .sys_rst_o(rst_h), .pwr_fail_no(pf_n2)
  );

  function automatic bit in_rst();
    return rst_l == 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // R8: the active-high copy must mirror the active-low one
  task automatic check_pol();
    check(rst_h == ~rst_l, "R8 polarity", int'(rst_h), int'(~rst_l));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_run(input bit lvl, output int n);
    n = 0;
    while (in_rst() == lvl && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int per(input int sel);
    return BASE << sel;
  endfunction

  task automatic t_reset_state();
    int n;
    cycles(3);
    check_eq("R11 reset asserted in reset", int'(in_rst()), 1);
    check_eq("R11 pf low in reset", int'(pf_n), 0);
    check_pol();
    rst_n = 1'b1;
    @(negedge clk);
    count_run(1'b1, n);
    check_eq("R11 R2 release after por", n, per(2) + 1);
  endtask

  task automatic t_drop_and_sel();
    int n;
    for (int sel = 0; sel < 4; sel++) begin
      tsel = 2'(sel);
      cycles(2);
      sup[sel % 3] = 1'b0;
      cycles(2);
      check_eq("R1 not yet asserted after 2 edges", int'(in_rst()), 0);
      cycles(1);
      check_eq("R1 asserted after 3 edges", int'(in_rst()), 1);
      check_pol();
      cycles(5);
      sup[sel % 3] = 1'b1;
      @(negedge clk);
      count_run(1'b1, n);
      check_eq("R3 R2 hold-off per select code", n, per(sel) + 1);
    end
  endtask

  task automatic t_restart();
    int n;
    tsel = 2'd1;
    sup[0] = 1'b0;
    cycles(5);
    sup[0] = 1'b1;
    cycles(4);
    check_eq("R2 still held mid count", int'(in_rst()), 1);
    sup[1] = 1'b0;
    cycles(3);
    sup[1] = 1'b1;
    @(negedge clk);
    count_run(1'b1, n);
    check_eq("R2 count restarts on re-drop", n, per(1) + 1);
  endtask

  task automatic t_tick_gate();
    int n;
    tsel = 2'd0;
    tick = 1'b0;
    sup[2] = 1'b0;
    cycles(5);
    sup[2] = 1'b1;
    cycles(200);
    check_eq("R10 no release without tick", int'(in_rst()), 1);
    tick = 1'b1;
    @(negedge clk);
    count_run(1'b1, n);
    check_eq("R10 release after ticks resume", n, per(0) - 1);
  endtask

  task automatic t_manual_pf();
    int n;
    tsel = 2'd2;
    cycles(3);
    man = 1'b1;
    cycles(2);
    check_eq("R7 manual not yet after 2 edges", int'(in_rst()), 0);
    cycles(1);
    check_eq("R7 manual asserts after 3 edges", int'(in_rst()), 1);
    pok = 1'b0;
    cycles(1);
    check_eq("R9 pf latency 1 edge unchanged", int'(pf_n), 1);
    cycles(1);
    check_eq("R9 pf low during manual reset", int'(pf_n), 0);
    pok = 1'b1;
    cycles(2);
    check_eq("R9 pf high again", int'(pf_n), 1);
    man = 1'b0;
    @(negedge clk);
    count_run(1'b1, n);
    check_eq("R7 hold after manual release", n, per(2) + 1);
    pok = 1'b0;
    cycles(2);
    check_eq("R9 pf low, no reset", int'(pf_n), 0);
    check_eq("R9 reset untouched by pf", int'(in_rst()), 0);
    pok = 1'b1;
    cycles(2);
  endtask

  task automatic man_pulse();
    int n;
    man = 1'b1;
    cycles(5);
    man = 1'b0;
    count_run(1'b1, n);
  endtask

  task automatic t_wd_expire();
    int n;
    tsel = 2'd0;
    strobe = 1'b0;
    wd_en = 1'b1;
    cycles(3);
    man_pulse();
    count_run(1'b0, n);
    check_eq("R5 gap before first pulse", n, WD + 1);
    count_run(1'b1, n);
    check_eq("R5 pulse width", n, per(0));
    count_run(1'b0, n);
    check_eq("R5 watchdog restarts after pulse", n, WD + 1);
    check_pol();
    count_run(1'b1, n);
  endtask

  task automatic t_wd_edges();
    int n;
    int hits = 0;
    tsel = 2'd1;
    man_pulse();
    for (int k = 0; k < 16; k++) begin
      strobe = ~strobe;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (in_rst()) hits++;
      end
    end
    check_eq("R4 both edges keep watchdog quiet", hits, 0);
    strobe = 1'b1;
    cycles(10);
    strobe = 1'b0;
    @(negedge clk);
    count_run(1'b0, n);
    check_eq("R4 expiry after last falling edge", n, WD + 3);
    count_run(1'b1, n);
    check_eq("R5 pulse width select 1", n, per(1));
  endtask

  task automatic t_wd_disabled();
    int n;
    int hits = 0;
    wd_en = 1'b0;
    cycles(3);
    for (int c = 0; c < 3 * WD; c++) begin
      @(negedge clk);
      if (in_rst()) hits++;
    end
    check_eq("R6 disabled watchdog never resets", hits, 0);
    wd_en = 1'b1;
    @(negedge clk);
    count_run(1'b0, n);
    check_eq("R6 expiry after enable", n, WD + 2);
    count_run(1'b1, n);
    wd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_drop_and_sel();
    t_restart();
    t_tick_gate();
    t_manual_pf();
    t_wd_expire();
    t_wd_edges();
    t_wd_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule